// File: doc/BRIEF.md
# MSI Doorbell Interrupt Collector

This block gathers message-signalled interrupts on the host side of a PCIe root port. Software programs a doorbell address of up to 64 bits, a per-vector enable word, a per-vector mask word and a pending-status word through a 32-bit register port. Each memory write the port observes arrives at the block as an address and 32 bits of data. When the address falls inside the 4-byte doorbell window, the data selects one vector, and the status bit for that vector is latched if the vector is enabled.

A single level-sensitive interrupt line goes to the host processor. It rises when an unmasked vector becomes pending. It then stays high until a software write to the status word leaves that word entirely zero. Software acknowledges vectors by writing a toggle pattern to the status register, not a clear pattern. Raising a mask bit later does not drop the line.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: After reset the doorbell address, enable, mask and status registers all read as zero and `irq` is low.
- R2: The doorbell address low word is at offset 0x820 and the high word is at 0x824. A write to one word leaves the other word unchanged, and both read back what was written.
- R3: The enable word is at 0x828 and the mask word at 0x82C, and both read back their stored value. Any other offset reads as zero, and a write to another offset changes no register.
- R4: A doorbell write whose address lies from the base up to base+3 sets status bit N, where N is the value of data bits [4:0]. A write at any other address changes nothing.
- R5: The status bit is set only when enable bit N is 1. While the enable word is zero the window does not respond at all.
- R6: A doorbell write whose data is 32 or greater (any of data bits [31:5] set) is ignored.
- R7: A register write to the status word at offset 0x830 XORs the written value into status, so it can clear bits and also set them.
- R8: `irq` rises at the clock edge where status gains a bit whose mask bit is 0. The mask used is the value the mask register held before that edge, so clearing a mask bit over a pending vector raises `irq` one cycle after the mask write.
- R9: Once high, `irq` stays high through mask changes and partial acknowledges. It falls only at a status write that leaves the status word zero.
- R10: When a status write and a doorbell hit occur in the same cycle, the XOR is applied first and the doorbell bit is ORed in after it.
- R11: A doorbell hit on a masked vector still records the status bit, but it does not raise `irq`.
- R12: Register reads return data one clock after the offset is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the offset |
| db_valid | input | 1 | Observed memory write is valid this cycle |
| db_addr | input | 64 | Address of the observed memory write |
| db_data | input | 32 | Little-endian data of the observed memory write |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench first programs a base address and an enable word that is only partly set. It then walks a table of doorbell writes: the first and last byte of the window, one byte below it, one byte above it, a base that differs only in the high word, a vector that is disabled, and data values of 32 or more. Together these show whether window matching, enable gating and data-range rejection are each decided on the correct bits. Directed sequences then exercise the toggle behaviour of status writes, the rule that `irq` holds until the whole word is zero, masked-pending followed by an unmask, a zero enable word, and same-cycle collisions between an acknowledge and a doorbell. These last separate the XOR-then-OR order from the reverse order.

// File: rtl/msi_db_pkg.sv
package msi_db_pkg;
   // Register offsets; software decodes these, so they are fixed.
   localparam logic [11:0] OFS_BASE_LO = 12'h820;
   localparam logic [11:0] OFS_BASE_HI = 12'h824;
   localparam logic [11:0] OFS_ENABLE  = 12'h828;
   localparam logic [11:0] OFS_MASK    = 12'h82C;
   localparam logic [11:0] OFS_STATUS  = 12'h830;

   localparam int unsigned BUS_DW = 32;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_BASE_LO,
      SEL_BASE_HI,
      SEL_ENABLE,
      SEL_MASK,
      SEL_STATUS
   } reg_sel_e;
endpackage

// File: rtl/msi_db_regs.sv
module msi_db_regs
   import msi_db_pkg::*;
#(
   parameter int unsigned REG_AW   = 12,
   parameter int unsigned DB_AW    = 64,
   parameter int unsigned VEC_W    = 32,
   parameter bit          READ_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [BUS_DW-1:0]   reg_wdata,
   input  logic [VEC_W-1:0]    status_q,
   output logic [BUS_DW-1:0]   reg_rdata,
   output logic [DB_AW-1:0]    db_base,
   output logic [VEC_W-1:0]    en_q,
   output logic [VEC_W-1:0]    mask_q,
   output logic                sts_we,
   output logic [VEC_W-1:0]    sts_wdata
);
   localparam int unsigned HI_W = DB_AW - BUS_DW;
   localparam logic [REG_AW-1:0] A_LO  = REG_AW'(OFS_BASE_LO);
   localparam logic [REG_AW-1:0] A_HI  = REG_AW'(OFS_BASE_HI);
   localparam logic [REG_AW-1:0] A_EN  = REG_AW'(OFS_ENABLE);
   localparam logic [REG_AW-1:0] A_MSK = REG_AW'(OFS_MASK);
   localparam logic [REG_AW-1:0] A_STS = REG_AW'(OFS_STATUS);

   reg_sel_e            sel;
   logic [DB_AW-1:0]    base_r;
   logic [VEC_W-1:0]    en_r;
   logic [VEC_W-1:0]    mask_r;
   logic [BUS_DW-1:0]   rd_mux;

   always_comb begin
      sel = SEL_NONE;
      if      (reg_addr == A_LO)  sel = SEL_BASE_LO;
      else if (reg_addr == A_HI)  sel = SEL_BASE_HI;
      else if (reg_addr == A_EN)  sel = SEL_ENABLE;
      else if (reg_addr == A_MSK) sel = SEL_MASK;
      else if (reg_addr == A_STS) sel = SEL_STATUS;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_r <= '0;
         en_r   <= '0;
         mask_r <= '0;
      end else if (reg_we) begin
         case (sel)
            SEL_BASE_LO: base_r[BUS_DW-1:0]     <= reg_wdata;
            SEL_BASE_HI: base_r[DB_AW-1:BUS_DW] <= reg_wdata[HI_W-1:0];
            SEL_ENABLE:  en_r                   <= reg_wdata[VEC_W-1:0];
            SEL_MASK:    mask_r                 <= reg_wdata[VEC_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_mux = '0;
      case (sel)
         SEL_BASE_LO: rd_mux = base_r[BUS_DW-1:0];
         SEL_BASE_HI: rd_mux = BUS_DW'(base_r[DB_AW-1:BUS_DW]);
         SEL_ENABLE:  rd_mux = BUS_DW'(en_r);
         SEL_MASK:    rd_mux = BUS_DW'(mask_r);
         SEL_STATUS:  rd_mux = BUS_DW'(status_q);
         default:     rd_mux = '0;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_flop
         logic [BUS_DW-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign reg_rdata = rd_q;
      end else begin : g_rd_comb
         assign reg_rdata = rd_mux;
      end
   endgenerate

   assign db_base   = base_r;
   assign en_q      = en_r;
   assign mask_q    = mask_r;
   assign sts_we    = reg_we && (sel == SEL_STATUS);
   assign sts_wdata = reg_wdata[VEC_W-1:0];
endmodule

// File: rtl/msi_db_match.sv
module msi_db_match
   import msi_db_pkg::*;
#(
   parameter int unsigned DB_AW     = 64,
   parameter int unsigned VEC_W     = 32,
   parameter int unsigned WIN_BYTES = 4
) (
   input  logic                db_valid,
   input  logic [DB_AW-1:0]    db_addr,
   input  logic [BUS_DW-1:0]   db_data,
   input  logic [DB_AW-1:0]    db_base,
   input  logic [VEC_W-1:0]    en_q,
   output logic [VEC_W-1:0]    set_vec
);
   localparam int unsigned IDX_W = $clog2(VEC_W);

   logic [DB_AW-1:0] ofs;
   logic             in_win;
   logic             idx_ok;
   logic             hit;

   // Unsigned distance from the base; anything below the base wraps high.
   assign ofs    = db_addr - db_base;
   assign in_win = (ofs < DB_AW'(WIN_BYTES));
   assign idx_ok = (db_data[BUS_DW-1:IDX_W] == '0);
   assign hit    = db_valid && in_win && idx_ok && (|en_q);

   generate
      for (genvar i = 0; i < VEC_W; i++) begin : g_vec
         assign set_vec[i] = hit && en_q[i] && (db_data[IDX_W-1:0] == IDX_W'(i));
      end
   endgenerate
endmodule

// File: rtl/msi_db_pending.sv
module msi_db_pending #(
   parameter int unsigned VEC_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sts_we,
   input  logic [VEC_W-1:0]  sts_wdata,
   input  logic [VEC_W-1:0]  set_vec,
   input  logic [VEC_W-1:0]  mask_q,
   output logic [VEC_W-1:0]  status_q,
   output logic              irq
);
   logic [VEC_W-1:0] after_sw;
   logic [VEC_W-1:0] status_nx;
   logic             raise;
   logic             drop;

   // Software toggle first, doorbell set second.
   assign after_sw  = sts_we ? (status_q ^ sts_wdata) : status_q;
   assign status_nx = after_sw | set_vec;
   assign raise     = |(status_nx & ~mask_q);
   assign drop      = sts_we && (status_nx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         irq      <= 1'b0;
      end else begin
         status_q <= status_nx;
         if (drop)       irq <= 1'b0;
         else if (raise) irq <= 1'b1;
      end
   end
endmodule

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl
   import msi_db_pkg::*;
#(
   parameter int unsigned REG_AW    = 12,
   parameter int unsigned DB_AW     = 64,
   parameter int unsigned VEC_W     = 32,
   parameter int unsigned WIN_BYTES = 4,
   parameter bit          READ_REG  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               db_valid,
   input  logic [DB_AW-1:0]   db_addr,
   input  logic [31:0]        db_data,
   output logic               irq
);
   generate
      if (VEC_W < 2 || VEC_W > BUS_DW || (VEC_W & (VEC_W - 1)) != 0) begin : g_bad_vec
         $error("VEC_W must be a power of two from 2 to 32");
      end
      if (DB_AW <= BUS_DW || DB_AW > 2 * BUS_DW) begin : g_bad_aw
         $error("DB_AW must lie in 33..64");
      end
      if (REG_AW < 12) begin : g_bad_reg
         $error("REG_AW must be at least 12");
      end
      if (WIN_BYTES < 1) begin : g_bad_win
         $error("WIN_BYTES must be nonzero");
      end
   endgenerate

   logic [DB_AW-1:0] db_base;
   logic [VEC_W-1:0] en_q;
   logic [VEC_W-1:0] mask_q;
   logic [VEC_W-1:0] status_q;
   logic [VEC_W-1:0] sts_wdata;
   logic [VEC_W-1:0] set_vec;
   logic             sts_we;

   msi_db_regs #(
      .REG_AW(REG_AW), .DB_AW(DB_AW), .VEC_W(VEC_W), .READ_REG(READ_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .status_q(status_q), .reg_rdata(reg_rdata),
      .db_base(db_base), .en_q(en_q), .mask_q(mask_q),
      .sts_we(sts_we), .sts_wdata(sts_wdata)
   );

   msi_db_match #(
      .DB_AW(DB_AW), .VEC_W(VEC_W), .WIN_BYTES(WIN_BYTES)
   ) u_match (
      .db_valid(db_valid), .db_addr(db_addr), .db_data(db_data),
      .db_base(db_base), .en_q(en_q), .set_vec(set_vec)
   );

   msi_db_pending #(
      .VEC_W(VEC_W)
   ) u_pend (
      .clk(clk), .rst_n(rst_n), .sts_we(sts_we), .sts_wdata(sts_wdata),
      .set_vec(set_vec), .mask_q(mask_q), .status_q(status_q), .irq(irq)
   );
endmodule

// File: rtl/msi_doorbell_chk.sv
module msi_doorbell_chk #(
   parameter int unsigned VEC_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic [VEC_W-1:0]  status_q,
   input logic [VEC_W-1:0]  mask_q,
   input logic [VEC_W-1:0]  en_q,
   input logic              sts_we
);
   // R8: a rising line needs an unmasked pending vector under the old mask.
   a_r8_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ((status_q & ~$past(mask_q)) != '0));

   // R9: the line falls only on a status write that empties the word.
   a_r9_irq_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> ($past(sts_we) && status_q == '0));

   // R9: a nonzero status word keeps a high line high.
   a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq) && status_q != '0) |-> irq);

   // R5: without a status write, new bits appear only where enabled.
   a_r5_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sts_we) |-> ((status_q & ~$past(status_q) & ~$past(en_q)) == '0));

   // R4: a doorbell adds at most one bit per cycle.
   a_r4_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sts_we) |-> ($countones(status_q & ~$past(status_q)) <= 1));

   // R7: only a status write can remove a pending bit.
   a_r7_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sts_we) |-> (($past(status_q) & ~status_q) == '0));
endmodule

bind msi_doorbell_ctrl msi_doorbell_chk #(.VEC_W(VEC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .status_q(status_q),
   .mask_q(mask_q), .en_q(en_q), .sts_we(sts_we)
);

// File: tb/sim_msi_doorbell_ctrl.sv
`timescale 1ns/1ps
module sim_msi_doorbell_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        db_valid = 1'b0;
   logic [63:0] db_addr = '0;
   logic [31:0] db_data = '0;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   localparam logic [63:0] BASE = 64'h0000_0012_3456_7800;
   localparam logic [31:0] ENAB = 32'hFFFF_0F0F;
   localparam int NV = 9;
   localparam logic [63:0] T_OFS [NV] = '{64'd0, 64'd3, 64'd4, 64'hFFFF_FFFF_FFFF_FFFF,
                                          64'd2, 64'd1, 64'd0, 64'd0, 64'h0000_0100_0000_0000};
   localparam logic [31:0] T_DAT [NV] = '{32'd3, 32'd8, 32'd1, 32'd1, 32'd4, 32'd31,
                                          32'd32, 32'h0000_0105, 32'd0};
   localparam logic [31:0] T_EXP [NV] = '{32'h0000_0008, 32'h0000_0100, 32'h0, 32'h0, 32'h0,
                                          32'h8000_0000, 32'h0, 32'h0, 32'h0};

   msi_doorbell_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_valid(db_valid),
      .db_addr(db_addr), .db_data(db_data), .irq(irq)
   );

   always #2 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      @(negedge clk);
      d = reg_rdata;
   endtask

   task automatic ring(input logic [63:0] a, input logic [31:0] d);
      @(negedge clk);
      db_valid = 1'b1; db_addr = a; db_data = d;
      @(negedge clk);
      db_valid = 1'b0;
   endtask

   task automatic ring_and_ack(input logic [31:0] ack, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 12'h830; reg_wdata = ack;
      db_valid = 1'b1; db_addr = BASE; db_data = d;
      @(negedge clk);
      reg_we = 1'b0; db_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(12'h820, v); chk("R1 base lo", v, 32'h0);
      rd(12'h824, v); chk("R1 base hi", v, 32'h0);
      rd(12'h828, v); chk("R1 enable", v, 32'h0);
      rd(12'h82C, v); chk("R1 mask", v, 32'h0);
      rd(12'h830, v); chk("R1 status", v, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);

      // R2 independent halves; R12 one-cycle read
      wr(12'h820, 32'hDEAD_BEEF);
      wr(12'h824, 32'h0000_0012);
      rd(12'h820, v); chk("R2 R12 lo readback", v, 32'hDEAD_BEEF);
      wr(12'h820, BASE[31:0]);
      rd(12'h824, v); chk("R2 hi unchanged", v, 32'h0000_0012);
      rd(12'h820, v); chk("R2 lo rewritten", v, BASE[31:0]);

      // R3 enable/mask readback, unmapped offset
      wr(12'h828, ENAB);
      wr(12'h82C, 32'h1234_5678);
      rd(12'h828, v); chk("R3 enable", v, ENAB);
      rd(12'h82C, v); chk("R3 mask", v, 32'h1234_5678);
      wr(12'h834, 32'hFFFF_FFFF);
      rd(12'h834, v); chk("R3 unmapped read", v, 32'h0);
      rd(12'h82C, v); chk("R3 mask untouched", v, 32'h1234_5678);
      rd(12'h828, v); chk("R3 enable untouched", v, ENAB);
      wr(12'h82C, 32'h0);

      // R4 R5 R6 doorbell table walk
      for (int i = 0; i < NV; i++) begin
         ring(BASE + T_OFS[i], T_DAT[i]);
         rd(12'h830, v); chk($sformatf("R4 R5 R6 status vec%0d", i), v, T_EXP[i]);
         chk($sformatf("R8 irq vec%0d", i), {31'b0, irq}, {31'b0, T_EXP[i] != 0});
         wr(12'h830, T_EXP[i]);
      end
      rd(12'h830, v); chk("R7 status cleared by toggle", v, 32'h0);

      // R7 XOR behaviour
      wr(12'h830, 32'h5);
      rd(12'h830, v); chk("R7 set by write", v, 32'h5);
      wr(12'h830, 32'h6);
      rd(12'h830, v); chk("R7 toggle", v, 32'h3);
      chk("R9 irq held partial", {31'b0, irq}, 32'h1);
      wr(12'h830, 32'h3);
      chk("R9 irq drops at zero", {31'b0, irq}, 32'h0);

      // R9 hold under mask and partial ack
      ring(BASE, 32'd0);
      ring(BASE, 32'd1);
      chk("R8 irq on doorbell", {31'b0, irq}, 32'h1);
      wr(12'h82C, 32'hFFFF_FFFF);
      chk("R9 irq held by mask", {31'b0, irq}, 32'h1);
      wr(12'h830, 32'h1);
      chk("R9 irq held one left", {31'b0, irq}, 32'h1);
      wr(12'h830, 32'h2);
      chk("R9 irq fall", {31'b0, irq}, 32'h0);

      // R11 masked pending, then unmask
      wr(12'h82C, 32'h1);
      ring(BASE, 32'd0);
      rd(12'h830, v); chk("R11 masked status", v, 32'h1);
      chk("R11 masked no irq", {31'b0, irq}, 32'h0);
      wr(12'h82C, 32'h0);
      @(negedge clk);
      chk("R8 irq after unmask", {31'b0, irq}, 32'h1);
      wr(12'h830, 32'h1);

      // R5 enable zero disables window
      wr(12'h828, 32'h0);
      ring(BASE, 32'd0);
      rd(12'h830, v); chk("R5 enable zero", v, 32'h0);
      chk("R5 no irq", {31'b0, irq}, 32'h0);
      wr(12'h828, ENAB);

      // R10 same-cycle order
      wr(12'h830, 32'h1);
      ring_and_ack(32'h1, 32'd0);
      rd(12'h830, v); chk("R10 xor then or", v, 32'h1);
      chk("R10 irq stays", {31'b0, irq}, 32'h1);
      wr(12'h830, 32'h1);
      ring_and_ack(32'h4, 32'd3);
      rd(12'h830, v); chk("R10 combined", v, 32'hC);
      wr(12'h830, 32'hC);
      chk("R9 final drop", {31'b0, irq}, 32'h0);

      finish_run();
   end
endmodule